// File: doc/BRIEF.md
# Fault Status Capture Register

This block records bus and memory-protection faults for a small processor subsystem. The bus and protection logic raise single-cycle event strobes, each with the address involved where there is one. The block keeps sticky status bits and two address registers. One address register is for precise data bus errors and one is for memory-management faults that carry an address. Each address register has a valid flag. The fault type decides whether an event only sets its status bit or also loads an address and sets the valid flag.

Instruction-fetch bus errors are reported at prefetch but are not recorded at that point. The block holds such an error as pending. It sets the status bit only when the faulting instruction is signalled as issued, and a flush before issue drops the pending error. Software reads three words through a combinational read port and clears status bits by writing ones to the status word. Exception entry, stacking, prioritisation and handler dispatch are handled elsewhere.

Top module: `fault_capture`

## Requirements
- R1: After an active-low reset, the status word, both address words and the pending fetch error are all zero. Select value 3 always reads zero.
- R2: Read select 0 returns the status word, select 1 the bus fault address and select 2 the memory-management fault address. The status bits are: 15 bus address valid, 11 bus fault on unstacking, 10 imprecise data bus error, 9 precise data bus error, 8 instruction bus error, 7 memory-management address valid, 4 access violation on stacking, 3 access violation on unstacking. Every other status bit reads zero.
- R3: A precise bus error event sets bits 9 and 15. If bit 15 was clear before the event, the event also loads bus_addr_i into the bus fault address word.
- R4: An imprecise bus error event sets bit 10 and an unstacking bus fault event sets bit 11. Neither event changes the bus fault address word.
- R5: An addressed memory-management event sets bit 7 and, if bit 7 was clear, loads mm_addr_i into the memory-management address word. Stacking and unstacking violations set bits 4 and 3 and leave that word unchanged.
- R6: A status bit stays set until software writes to select 0 with a 1 in that bit position. Writing 0 to a bit has no effect.
- R7: When a fault event sets a bit in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R8: While a valid flag (bit 15 or bit 7) is set, a further addressed fault of that class does not change its address word.
- R9: A prefetch error is held pending. Bit 8 is set in the cycle after an issue strobe that sees the error pending. A flush or an issue consumes the pending error, and a flush before issue means bit 8 is never set for it.
- R10: Imprecise and precise bus errors can both be recorded, so bits 10 and 9 can read 1 together.
- R11: Writes to select 1, 2 or 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_precise_i | input | 1 | Precise data bus error event |
| bus_imprecise_i | input | 1 | Imprecise data bus error event |
| bus_unstack_i | input | 1 | Bus fault on unstacking event |
| bus_addr_i | input | ADDR_W | Address for a precise bus error |
| mm_access_i | input | 1 | Memory-management fault that carries an address |
| mm_stack_i | input | 1 | Access violation on stacking |
| mm_unstack_i | input | 1 | Access violation on unstacking |
| mm_addr_i | input | ADDR_W | Address for an addressed memory-management fault |
| ifetch_err_i | input | 1 | Bus error seen at instruction prefetch |
| ifetch_issue_i | input | 1 | The prefetched instruction is issued |
| ifetch_flush_i | input | 1 | The prefetch is discarded |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Word select: 0 status, 1 bus address, 2 mm address |
| reg_wdata_i | input | 32 | Write data, ones clear status bits |
| reg_rdata_o | output | 32 | Combinational read data for the selected word |

## Verification
On every cycle the assertions check several properties. A set bit survives any cycle without a clearing write, and an event always leaves its bit set. A valid flag freezes its address word, and a load captures the address presented with the event. Unaddressed bus events and writes to the address words leave the bus address unchanged, and reserved status bits stay zero. A rising bit 8 must follow an issue strobe. The bench scenarios are needed for the orderings across several cycles: a flush between prefetch error and issue, first-address retention over a sequence of faults, and each single-bit write-one-to-clear pattern. The bench also sweeps every combination of events, together with mixed clear writes.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_STAT  = 2'd0,
    SEL_BADDR = 2'd1,
    SEL_MADDR = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int B_BUS_VLD   = 15;
  localparam int B_UNSTK_BUS = 11;
  localparam int B_IMPRECISE = 10;
  localparam int B_PRECISE   = 9;
  localparam int B_IFETCH    = 8;
  localparam int B_MM_VLD    = 7;
  localparam int B_MM_STACK  = 4;
  localparam int B_MM_UNSTK  = 3;

  localparam logic [WORD_W-1:0] STAT_MASK = 32'h0000_8F98;
endpackage

// File: rtl/fault_sticky_bit.sv
module fault_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= set_i | (q & ~clr_i);
  end

  assign q_o = q;

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  assert_sticky_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_o && !clr_i |=> q_o);
  assert_no_spurious_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_o && !set_i |=> !q_o);
endmodule

// File: rtl/fault_addr_reg.sv
module fault_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_vld_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= ev_i | (vld_q & ~clr_vld_i);
      // first address wins until software drops the valid flag
      if (ev_i && !vld_q) addr_q <= addr_i;
    end
  end

  assign vld_o  = vld_q;
  assign addr_o = addr_q;

  assert_addr_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i && !vld_o |=> vld_o && (addr_o == $past(addr_i)));
  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> $stable(addr_o));
  assert_vld_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> vld_o);
endmodule

// File: rtl/fault_ifetch_track.sv
module fault_ifetch_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic issue_i,
  input  logic flush_i,
  output logic hit_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= err_i | (pend_q & ~issue_i & ~flush_i);
  end

  assign hit_o = issue_i & pend_q;

  assert_flush_discards_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !err_i |=> !hit_o);
  assert_issue_consumes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i && !err_i |=> !hit_o);
endmodule

// File: rtl/fault_capture.sv
module fault_capture
  import fault_capture_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_precise_i,
  input  logic              bus_imprecise_i,
  input  logic              bus_unstack_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              mm_access_i,
  input  logic              mm_stack_i,
  input  logic              mm_unstack_i,
  input  logic [ADDR_W-1:0] mm_addr_i,
  input  logic              ifetch_err_i,
  input  logic              ifetch_issue_i,
  input  logic              ifetch_flush_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  localparam int PAD_W = WORD_W - ADDR_W;

  reg_sel_e          sel;
  logic [WORD_W-1:0] set_vec, clr_vec, stat;
  logic [ADDR_W-1:0] baddr, maddr;
  logic              bvld, mvld, if_hit;
  logic              unused_nc;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign clr_vec = (reg_we_i && sel == SEL_STAT) ? reg_wdata_i : '0;

  fault_ifetch_track i_ifetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (ifetch_err_i),
    .issue_i (ifetch_issue_i),
    .flush_i (ifetch_flush_i),
    .hit_o   (if_hit)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[B_PRECISE]   = bus_precise_i;
    set_vec[B_IMPRECISE] = bus_imprecise_i;
    set_vec[B_UNSTK_BUS] = bus_unstack_i;
    set_vec[B_IFETCH]    = if_hit;
    set_vec[B_MM_STACK]  = mm_stack_i;
    set_vec[B_MM_UNSTK]  = mm_unstack_i;
  end

  fault_addr_reg #(.ADDR_W(ADDR_W)) i_bus_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (bus_precise_i),
    .addr_i    (bus_addr_i),
    .clr_vld_i (clr_vec[B_BUS_VLD]),
    .vld_o     (bvld),
    .addr_o    (baddr)
  );

  fault_addr_reg #(.ADDR_W(ADDR_W)) i_mm_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (mm_access_i),
    .addr_i    (mm_addr_i),
    .clr_vld_i (clr_vec[B_MM_VLD]),
    .vld_o     (mvld),
    .addr_o    (maddr)
  );

  // plain sticky bits; valid flags come from the address registers
  for (genvar b = 0; b < WORD_W; b++) begin : g_stat
    if (b == B_BUS_VLD) begin : g_bv
      assign stat[b] = bvld;
    end else if (b == B_MM_VLD) begin : g_mv
      assign stat[b] = mvld;
    end else if (STAT_MASK[b]) begin : g_bit
      fault_sticky_bit i_bit (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_vec[b]),
        .clr_i  (clr_vec[b]),
        .q_o    (stat[b])
      );
    end else begin : g_rsvd
      assign stat[b] = 1'b0;
    end
  end

  assign unused_nc = ^{set_vec & ~STAT_MASK, clr_vec & ~STAT_MASK};

  always_comb begin
    unique case (sel)
      SEL_STAT:  reg_rdata_o = stat;
      SEL_BADDR: reg_rdata_o = {{PAD_W{1'b0}}, baddr};
      SEL_MADDR: reg_rdata_o = {{PAD_W{1'b0}}, maddr};
      default:   reg_rdata_o = '0;
    endcase
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_STAT) |-> ((reg_rdata_o & ~STAT_MASK) == '0));
  assert_bus_addr_untouched_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_imprecise_i || bus_unstack_i) && !bus_precise_i |=> $stable(baddr));
  assert_mm_addr_untouched_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_stack_i || mm_unstack_i) && !mm_access_i |=> $stable(maddr));
  assert_addr_write_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && sel != SEL_STAT && !bus_precise_i && !mm_access_i |=> $stable(baddr) && $stable(maddr));
  assert_ifetch_at_issue_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat[B_IFETCH]) |-> $past(ifetch_issue_i));
endmodule

// File: tb/test_fault_capture.sv
module test_fault_capture;
  localparam int AW = 32;
  localparam logic [31:0] IMPL = 32'h0000_8F98;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic precise = 0, imprecise = 0, unstk = 0, mm_acc = 0, mm_stk = 0, mm_unstk = 0;
  logic if_err = 0, if_issue = 0, if_flush = 0, we = 0;
  logic [1:0] sel = 2'd0;
  logic [AW-1:0] baddr_in = '0, maddr_in = '0;
  logic [31:0] wdata = '0, rdata;

  int checks = 0, fails = 0;
  logic [31:0] e_stat = '0, e_baddr = '0, e_maddr = '0;
  logic e_pend = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_capture #(.ADDR_W(AW)) i_fault_capture (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_precise_i(precise), .bus_imprecise_i(imprecise), .bus_unstack_i(unstk),
    .bus_addr_i(baddr_in),
    .mm_access_i(mm_acc), .mm_stack_i(mm_stk), .mm_unstack_i(mm_unstk),
    .mm_addr_i(maddr_in),
    .ifetch_err_i(if_err), .ifetch_issue_i(if_issue), .ifetch_flush_i(if_flush),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    sel = 2'd0; #1 chk({tag, " status R2"}, rdata, e_stat);
    sel = 2'd1; #1 chk({tag, " bus addr R3"}, rdata, e_baddr);
    sel = 2'd2; #1 chk({tag, " mm addr R5"}, rdata, e_maddr);
    sel = 2'd3; #1 chk({tag, " sel3 R1"}, rdata, 32'h0);
  endtask

  // ev: 0 precise,1 imprecise,2 unstack bus,3 mm addr,4 mm stack,5 mm unstack,6 if err,7 issue,8 flush
  task automatic step(input logic [8:0] ev, input logic [31:0] ba, input logic [31:0] ma,
                      input logic w, input logic [1:0] s, input logic [31:0] wd, input string tag);
    logic [31:0] set_m, clr_m;
    @(negedge clk);
    {if_flush, if_issue, if_err, mm_unstk, mm_stk, mm_acc, unstk, imprecise, precise} = ev;
    baddr_in = ba; maddr_in = ma; we = w; sel = s; wdata = wd;
    clr_m = (w && s == 2'd0) ? wd : 32'h0;
    set_m = 32'h0;
    set_m[9] = ev[0]; set_m[15] = ev[0]; set_m[10] = ev[1]; set_m[11] = ev[2];
    set_m[7] = ev[3]; set_m[4] = ev[4]; set_m[3] = ev[5]; set_m[8] = ev[7] & e_pend;
    if (ev[0] && !e_stat[15]) e_baddr = ba;
    if (ev[3] && !e_stat[7]) e_maddr = ma;
    e_stat = ((e_stat & ~clr_m) | set_m) & IMPL;
    e_pend = ev[6] | (e_pend & ~ev[7] & ~ev[8]);
    @(negedge clk);
    {if_flush, if_issue, if_err, mm_unstk, mm_stk, mm_acc, unstk, imprecise, precise} = '0;
    we = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("reset R1");
    rst_n = 1'b1;
    check_all("reset R1");

    // R8: first precise address kept; R3 load
    step(9'h001, 32'h1111_0000, 0, 0, 0, 0, "R3 first load");
    step(9'h001, 32'h2222_0000, 0, 0, 0, 0, "R8 bus hold");
    step(9'h008, 0, 32'h3333_0000, 0, 0, 0, "R5 mm load");
    step(9'h008, 0, 32'h4444_0000, 0, 0, 0, "R8 mm hold");
    step(9'h030, 0, 32'h5555_0000, 0, 0, 0, "R5 stack unstack");
    step(9'h006, 32'h6666_0000, 0, 0, 0, 0, "R4 no bus addr");
    // R10 both bits together
    step(9'h000, 0, 0, 1, 0, 32'hFFFF_FFFF, "R6 clear all");
    step(9'h003, 32'h7777_0000, 0, 0, 0, 0, "R10 imprecise and precise");
    sel = 2'd0; #1 chk("R10 bits 10 and 9", rdata & 32'h600, 32'h600);
    // R11 address word writes ignored
    step(9'h000, 0, 0, 1, 1, 32'h0, "R11 write bus addr");
    step(9'h000, 0, 0, 1, 2, 32'h0, "R11 write mm addr");
    step(9'h000, 0, 0, 1, 3, 32'hFFFF_FFFF, "R11 write sel3");
    // R7 set wins over clear
    step(9'h03F, 32'h8888_0000, 32'h9999_0000, 1, 0, 32'hFFFF_FFFF, "R7 set beats clear");
    // R9 flush discards, issue later records
    step(9'h000, 0, 0, 1, 0, 32'hFFFF_FFFF, "R6 clear all");
    step(9'h040, 0, 0, 0, 0, 0, "R9 prefetch error");
    sel = 2'd0; #1 chk("R9 not at prefetch", rdata & 32'h100, 32'h0);
    step(9'h100, 0, 0, 0, 0, 0, "R9 flush");
    step(9'h080, 0, 0, 0, 0, 0, "R9 issue after flush");
    sel = 2'd0; #1 chk("R9 flushed error dropped", rdata & 32'h100, 32'h0);
    step(9'h040, 0, 0, 0, 0, 0, "R9 prefetch error");
    step(9'h000, 0, 0, 0, 0, 0, "R9 wait");
    step(9'h080, 0, 0, 0, 0, 0, "R9 issue");
    sel = 2'd0; #1 chk("R9 recorded at issue", rdata & 32'h100, 32'h100);

    // R6 single-bit write-one-to-clear and write-zero sweep
    for (int b = 0; b < 32; b++) begin
      step(9'h0FF, 32'hB000_0000 + b, 32'hC000_0000 + b, 0, 0, 0, "R6 set all");
      step(9'h080, 0, 0, 0, 0, 0, "R6 issue");
      step(9'h000, 0, 0, 1, 0, 32'h1 << b, "R6 w1c bit");
      step(9'h000, 0, 0, 1, 0, ~(32'h1 << b), "R6 write zero bit");
    end

    // exhaustive event combinations with mixed writes
    for (int i = 0; i < 512; i++) begin
      logic w;
      logic [1:0] s;
      logic [31:0] wd;
      w  = (i % 3 == 0) || (i % 5 == 0) || (i % 7 == 0);
      s  = (i % 5 == 0) ? 2'(1 + (i % 3)) : 2'd0;
      wd = (i % 7 == 0) ? 32'hFFFF_FFFF : 32'(i) * 32'h9E37_79B1;
      step(9'(i), 32'h1000_0000 + 32'(i) * 4, 32'hA000_0000 ^ (32'(i) << 3), w, s, wd,
           "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 sweep");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule